// File: doc/BRIEF.md
# Bi-Endian Misaligned Load/Store Unit

This unit sits between a processor core and a data memory organised as 32-bit words with per-byte write enables. The core hands it loads and stores of 1, 2 or 4 bytes at any byte address. With each request the core also gives a byte-order mode bit, which may change from one request to the next. The unit works out which byte lanes of which word or words hold the object. When the object crosses a word boundary, it makes two word accesses back to back. It then either assembles a right-justified load result (zero- or sign-extended) or writes only the lanes that belong to the object.

The memory convention is fixed. Byte address `a` lives in word `a >> 2`, lane `a % 4`, and lane `j` occupies bits `8j+7:8j` of the word. The memory returns read data one cycle after it is enabled. The request side uses valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. A requester may hold `req_valid` and its fields while `req_ready` is low: nothing is taken until the unit is idle again. The response is a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must take it in that cycle.

Top module: `bi_endian_lsu`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: When `big_endian` is 0, the least significant byte of an object of n bytes at address A is at A and its most significant byte is at A+n-1. For example, 0x12345678 stored at 0x100 reads back 0x78 as a byte at 0x100.
- R3: When `big_endian` is 1, the most significant byte is at A and the least significant byte is at A+n-1. For example, 0x12345678 stored at 0x100 reads back 0x12 as a byte at 0x100 and 0x78 at 0x103.
- R4: The mode bit is captured when a request is taken. Changing `big_endian` while that request is in progress has no effect on it.
- R5: A store writes exactly the lanes of the object in each word it touches. All other bytes keep their values. Reads drive `mem_be` to 0.
- R6: An object with (A mod 4) + n > 4 is handled as two memory accesses in consecutive cycles. The first goes to word A>>2 and the second to the next word address, which wraps to 0 at the top of the address space.
- R7: An object that fits inside one word uses exactly one memory access.
- R8: `req_ready` is 0 from the cycle after acceptance until the unit has returned to idle. Requests presented in that window are ignored.
- R9: `req_size` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. A 1- or 2-byte load is zero-extended when `req_signed` is 0 and sign-extended when it is 1. `rsp_data` is 0 except during a load response.
- R10: `rsp_valid` comes up for one cycle, N rising edges after the accepting edge, counting the accepting edge. N is 3 for a single-word load, 4 for a split load, 2 for a single-word store and 3 for a split store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Object size code (R9) |
| req_signed | input | 1 | Sign-extend a short load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| big_endian | input | 1 | Byte-order mode, sampled on acceptance |
| rsp_valid | output | 1 | Completion pulse for load or store |
| rsp_data | output | 32 | Load result |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Word write data |
| mem_rdata | input | 32 | Word read data, one cycle after `mem_en` |

## Verification
The checker watches several properties on every cycle. It confirms that no request is taken while an access is running and that back-to-back memory accesses target consecutive word addresses. It also checks that reads never assert lane enables, that writes always assert at least one, that an aligned word request makes a single access, and that the response lasts exactly one cycle. Byte placement in both modes, extension, preservation of neighbouring bytes, and immunity to a mode change mid-access can only be shown by the bench. It runs every size, offset and mode, including a store that wraps at the top of memory, and compares every load against a byte-array model.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFS_W      = $clog2(WORD_BYTES);
  localparam int WIN_BYTES  = 2 * WORD_BYTES;
  localparam int CNT_W      = $clog2(WORD_BYTES) + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FIRST   = 3'd1,
    ST_SECOND  = 3'd2,
    ST_COLLECT = 3'd3,
    ST_DONE    = 3'd4
  } state_e;

  function automatic logic [CNT_W-1:0] obj_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: obj_bytes = CNT_W'(1);
      SZ_HALF: obj_bytes = CNT_W'(2);
      default: obj_bytes = CNT_W'(WORD_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0]      wdata,
  input  logic [1:0]             size,
  input  logic [OFS_W-1:0]       ofs,
  input  logic                   big,
  output logic [8*WIN_BYTES-1:0] win_data,
  output logic [WIN_BYTES-1:0]   win_be
);
  localparam int REL_W = OFS_W + 2;

  logic [CNT_W-1:0] n;
  assign n = obj_bytes(size);

  for (genvar l = 0; l < WIN_BYTES; l++) begin : g_lane
    logic [REL_W-1:0] rel;
    logic             hit;
    logic [OFS_W-1:0] idx;
    assign rel = REL_W'(l) - REL_W'(ofs);
    assign hit = (REL_W'(l) >= REL_W'(ofs)) && (rel < REL_W'(n));
    assign idx = big ? OFS_W'(REL_W'(n) - REL_W'(1) - rel) : rel[OFS_W-1:0];
    assign win_be[l] = hit;
    assign win_data[8*l +: 8] = hit ? wdata[{idx, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_gather.sv
module lsu_load_gather
  import lsu_pkg::*;
(
  input  logic [8*WIN_BYTES-1:0] win,
  input  logic [1:0]             size,
  input  logic [OFS_W-1:0]       ofs,
  input  logic                   big,
  input  logic                   sgn,
  output logic [DATA_W-1:0]      data
);
  localparam int POS_W = $clog2(WIN_BYTES);

  logic [CNT_W-1:0] n;
  logic [7:0]       val_byte [WORD_BYTES];
  logic             ext;

  assign n = obj_bytes(size);

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_byte
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] lane;
    assign pos  = big ? POS_W'(POS_W'(n) - POS_W'(1) - POS_W'(i)) : POS_W'(i);
    assign lane = POS_W'(ofs) + pos;
    assign val_byte[i] = win[{lane, 3'b000} +: 8];
    assign data[8*i +: 8] = (CNT_W'(i) < n) ? val_byte[i] : {8{ext}};
  end

  always_comb begin
    case (n)
      CNT_W'(1): ext = sgn & val_byte[0][7];
      CNT_W'(2): ext = sgn & val_byte[1][7];
      default:   ext = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int WA_W  = ADDR_W - OFS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic                   req_signed,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic                   big_endian,
  output logic                   h_write,
  output logic [1:0]             h_size,
  output logic                   h_signed,
  output logic                   h_big,
  output logic [OFS_W-1:0]       h_ofs,
  output logic [DATA_W-1:0]      h_wdata,
  input  logic [8*WIN_BYTES-1:0] st_data,
  input  logic [WIN_BYTES-1:0]   st_be,
  output logic [8*WIN_BYTES-1:0] ld_win,
  output logic                   rsp_valid,
  output logic                   mem_en,
  output logic                   mem_we,
  output logic [WA_W-1:0]        mem_addr,
  output logic [WORD_BYTES-1:0]  mem_be,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata
);
  state_e           state_q, state_d;
  logic [WA_W-1:0]  word0_q;
  logic [WA_W-1:0]  word1;
  logic [CNT_W-1:0] n;
  logic             split;
  logic             accept;
  logic             second;

  assign n      = obj_bytes(h_size);
  assign split  = (CNT_W'(h_ofs) + n) > CNT_W'(WORD_BYTES);
  assign accept = req_valid && (state_q == ST_IDLE);
  assign word1  = word0_q + WA_W'(1);
  assign second = (state_q == ST_SECOND);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_FIRST;
      ST_FIRST:   state_d = split ? ST_SECOND : (h_write ? ST_DONE : ST_COLLECT);
      ST_SECOND:  state_d = h_write ? ST_DONE : ST_COLLECT;
      ST_COLLECT: state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      word0_q  <= '0;
      h_write  <= 1'b0;
      h_size   <= SZ_BYTE;
      h_signed <= 1'b0;
      h_big    <= 1'b0;
      h_ofs    <= '0;
      h_wdata  <= '0;
      ld_win   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        word0_q  <= req_addr[ADDR_W-1:OFS_W];
        h_ofs    <= req_addr[OFS_W-1:0];
        h_write  <= req_write;
        h_size   <= req_size;
        h_signed <= req_signed;
        h_big    <= big_endian;
        h_wdata  <= req_wdata;
      end
      if (second && !h_write) ld_win[DATA_W-1:0] <= mem_rdata;
      if (state_q == ST_COLLECT) begin
        if (split) ld_win[2*DATA_W-1:DATA_W] <= mem_rdata;
        else       ld_win[DATA_W-1:0]        <= mem_rdata;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign mem_en    = (state_q == ST_FIRST) || second;
  assign mem_we    = mem_en && h_write;
  assign mem_addr  = second ? word1 : word0_q;
  assign mem_be    = !mem_we ? '0 :
                     (second ? st_be[WIN_BYTES-1:WORD_BYTES] : st_be[WORD_BYTES-1:0]);
  assign mem_wdata = second ? st_data[2*DATA_W-1:DATA_W] : st_data[DATA_W-1:0];
endmodule

// File: rtl/bi_endian_lsu.sv
module bi_endian_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic                req_signed,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  input  logic                big_endian,
  output logic                rsp_valid,
  output logic [31:0]         rsp_data,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [3:0]          mem_be,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata
);
  logic                   h_write, h_signed, h_big;
  logic [1:0]             h_size;
  logic [OFS_W-1:0]       h_ofs;
  logic [DATA_W-1:0]      h_wdata;
  logic [8*WIN_BYTES-1:0] st_data;
  logic [WIN_BYTES-1:0]   st_be;
  logic [8*WIN_BYTES-1:0] ld_win;
  logic [DATA_W-1:0]      ld_value;

  lsu_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .big_endian(big_endian),
    .h_write(h_write), .h_size(h_size), .h_signed(h_signed), .h_big(h_big),
    .h_ofs(h_ofs), .h_wdata(h_wdata),
    .st_data(st_data), .st_be(st_be), .ld_win(ld_win),
    .rsp_valid(rsp_valid),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  lsu_store_pack u_pack (
    .wdata(h_wdata), .size(h_size), .ofs(h_ofs), .big(h_big),
    .win_data(st_data), .win_be(st_be)
  );

  lsu_load_gather u_gather (
    .win(ld_win), .size(h_size), .ofs(h_ofs), .big(h_big), .sgn(h_signed),
    .data(ld_value)
  );

  assign rsp_data = (rsp_valid && !h_write) ? ld_value : '0;
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [3:0]        mem_be
);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_consecutive_words: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == (ADDR_W-2)'($past(mem_addr) + 1'b1)));

  a_r7_aligned_word_once: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 2'd2 && req_addr[1:0] == 2'b00)
      |=> mem_en ##1 !mem_en);

  a_r5_read_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_be == 4'b0000));

  a_r5_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_be != 4'b0000));

  a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_data == 32'h0));

  a_r1_done_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_en && !req_ready));
endmodule

bind bi_endian_lsu lsu_checker #(.ADDR_W(ADDR_W)) u_lsu_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/tb_bi_endian_lsu.sv
module tb_bi_endian_lsu;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 10;
  localparam int NBYTES     = 1 << AW;
  localparam int NWORDS     = NBYTES / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic          req_signed = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          big_endian = 1'b0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic          mem_en, mem_we;
  logic [AW-3:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  logic [31:0] ram     [NWORDS];
  logic [7:0]  ref_mem [NBYTES];
  int          acc_total = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  bi_endian_lsu #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
    .req_addr(req_addr), .req_wdata(req_wdata), .big_endian(big_endian),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      acc_total <= acc_total + 1;
      if (mem_we) begin
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) ram[mem_addr][8*j +: 8] <= mem_wdata[8*j +: 8];
      end else begin
        mem_rdata <= ram[mem_addr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int byte_addr(input int a, input int i, input int n, input bit big);
    return (a + (big ? (n - 1 - i) : i)) % NBYTES;
  endfunction

  function automatic logic [31:0] exp_load(input int a, input logic [1:0] sz, input bit big, input bit sgn);
    int n = nbytes(sz);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = ref_mem[byte_addr(a, i, n, big)];
    if (sgn && n < 4 && v[8*n-1]) for (int i = n; i < 4; i++) v[8*i +: 8] = 8'hFF;
    return v;
  endfunction

  task automatic ref_store(input int a, input logic [1:0] sz, input bit big, input logic [31:0] d);
    int n = nbytes(sz);
    for (int i = 0; i < n; i++) ref_mem[byte_addr(a, i, n, big)] = d[8*i +: 8];
  endtask

  // One request; flip toggles the mode after acceptance (R4), junk holds a
  // different request on the inputs while busy (R8).
  task automatic run_op(input bit wr, input logic [1:0] sz, input bit sgn, input int a,
                        input logic [31:0] d, input bit big, input bit flip, input bit junk,
                        output logic [31:0] got);
    int n = nbytes(sz);
    bit split = ((a % 4) + n) > 4;
    int cnt;
    int acc0;
    int exp_lat;
    logic [31:0] exp_v;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sgn;
    req_addr = AW'(a); req_wdata = d; big_endian = big;
    acc0 = acc_total;
    @(posedge clk);
    cnt = 1;
    @(negedge clk);
    if (junk) begin
      req_write = 1'b1; req_size = 2'd2; req_addr = AW'((a + 8) % NBYTES); req_wdata = 32'hDEADBEEF;
    end else begin
      req_valid = 1'b0;
    end
    if (flip) big_endian = ~big;
    while (!rsp_valid && cnt < 20) begin
      @(posedge clk); cnt++; @(negedge clk);
    end
    req_valid = 1'b0;
    got = rsp_data;
    exp_lat = wr ? (split ? 3 : 2) : (split ? 4 : 3);
    check(cnt == exp_lat, "R10 latency", 32'(cnt), 32'(exp_lat));
    check((acc_total - acc0) == (split ? 2 : 1), split ? "R6 split access count" : "R7 single access count",
          32'(acc_total - acc0), split ? 32'd2 : 32'd1);
    if (wr) begin
      ref_store(a, sz, big, d);
      check(rsp_data == 32'h0, "R9 store response data", rsp_data, 32'h0);
    end else begin
      exp_v = exp_load(a, sz, big, sgn);
      check(rsp_data == exp_v, big ? "R3 load value" : "R2 load value", rsp_data, exp_v);
    end
  endtask

  initial begin
    logic [31:0] got;
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    for (int w = 0; w < NWORDS; w++) begin
      ram[w] = $urandom;
      for (int j = 0; j < 4; j++) ref_mem[4*w + j] = ram[w][8*j +: 8];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_en == 1'b0, "R1 reset mem_en", 32'(mem_en), 32'd0);
    rst_n = 1'b1;

    // R2: little-endian layout of a known word
    run_op(1'b1, 2'd2, 1'b0, 32'h100, 32'h12345678, 1'b0, 1'b0, 1'b0, got);
    run_op(1'b0, 2'd0, 1'b0, 32'h100, 32'h0, 1'b0, 1'b0, 1'b0, got);
    check(got == 32'h78, "R2 byte at lowest address", got, 32'h78);
    // R3: big-endian layout of the same word
    run_op(1'b1, 2'd2, 1'b0, 32'h100, 32'h12345678, 1'b1, 1'b0, 1'b0, got);
    run_op(1'b0, 2'd0, 1'b0, 32'h100, 32'h0, 1'b0, 1'b0, 1'b0, got);
    check(got == 32'h12, "R3 byte at lowest address", got, 32'h12);
    run_op(1'b0, 2'd0, 1'b0, 32'h103, 32'h0, 1'b1, 1'b0, 1'b0, got);
    check(got == 32'h78, "R3 byte at highest address", got, 32'h78);

    // R9: extension of short loads
    run_op(1'b1, 2'd0, 1'b0, 32'h121, 32'h00000080, 1'b0, 1'b0, 1'b0, got);
    run_op(1'b0, 2'd0, 1'b1, 32'h121, 32'h0, 1'b0, 1'b0, 1'b0, got);
    check(got == 32'hFFFFFF80, "R9 signed byte", got, 32'hFFFFFF80);
    run_op(1'b0, 2'd0, 1'b0, 32'h121, 32'h0, 1'b0, 1'b0, 1'b0, got);
    check(got == 32'h00000080, "R9 unsigned byte", got, 32'h00000080);
    run_op(1'b1, 2'd1, 1'b0, 32'h133, 32'h0000A5C3, 1'b1, 1'b0, 1'b0, got);
    run_op(1'b0, 2'd1, 1'b1, 32'h133, 32'h0, 1'b1, 1'b0, 1'b0, got);
    check(got == 32'hFFFFA5C3, "R9 signed split half", got, 32'hFFFFA5C3);
    run_op(1'b0, 2'd3, 1'b0, 32'h130, 32'h0, 1'b0, 1'b0, 1'b0, got);

    // R6: word store wrapping past the top of memory
    run_op(1'b1, 2'd2, 1'b0, NBYTES - 2, 32'hCAFEF00D, 1'b1, 1'b0, 1'b0, got);
    run_op(1'b0, 2'd2, 1'b0, NBYTES - 2, 32'h0, 1'b1, 1'b0, 1'b0, got);
    check(got == 32'hCAFEF00D, "R6 wrapped word", got, 32'hCAFEF00D);
    run_op(1'b0, 2'd1, 1'b0, 0, 32'h0, 1'b0, 1'b0, 1'b0, got);

    // R4: mode flipped during split accesses
    run_op(1'b1, 2'd2, 1'b0, 32'h203, 32'h0BADC0DE, 1'b1, 1'b1, 1'b0, got);
    run_op(1'b0, 2'd2, 1'b0, 32'h203, 32'h0, 1'b0, 1'b1, 1'b0, got);
    check(got == exp_load(32'h203, 2'd2, 1'b0, 1'b0), "R4 mode held", got, exp_load(32'h203, 2'd2, 1'b0, 1'b0));

    // R8: a second request held while busy is ignored; its target stays intact
    run_op(1'b1, 2'd1, 1'b0, 32'h301, 32'h00005A5A, 1'b0, 1'b0, 1'b1, got);
    run_op(1'b0, 2'd2, 1'b0, 32'h308, 32'h0, 1'b0, 1'b0, 1'b0, got);

    // R5: every size, offset and mode, neighbours verified by wide loads
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < 4; o++) begin
          int base = 32'h180 + 16 * (4 * s + o) % 128;
          run_op(1'b1, 2'(s), 1'b0, base + o, $urandom, m[0], 1'b0, 1'b0, got);
          run_op(1'b0, 2'(s), 1'b0, base + o, 32'h0, m[0], 1'b0, 1'b0, got);
          run_op(1'b0, 2'd2, 1'b0, base, 32'h0, 1'b0, 1'b0, 1'b0, got);
          run_op(1'b0, 2'd2, 1'b0, base + 4, 32'h0, 1'b0, 1'b0, 1'b0, got);
        end

    // Random mix
    for (int k = 0; k < 600; k++) begin
      run_op(1'($urandom), 2'($urandom), 1'($urandom), int'($urandom % NBYTES), $urandom,
             1'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0, got);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule